// File: doc/BRIEF.md
# NOR Flash Buffered-Program Sequencer

This block sits on the host side of a parallel NOR flash. It takes one request to program data into the flash's 512-byte write buffer and turns it into the bus write cycles the flash expects. Each buffer command has the same parts in order: two unlock writes, a load command and a count written to the sector address, one address/data write per unit, and a confirm write. Program data comes from a ready/valid source, one unit per data write. The block drives the address, data, chip-enable and write-enable lines. When the last cycle has ended it pulses `done`.

A request gives a start unit address, a unit count and a width select. In word mode (x16) a unit is a 16-bit word, so the buffer holds 256 units. In byte mode (x8) a unit is a byte, so the buffer holds 512 units. The count field in the command is one byte wide, which caps a single command at 256 units. A byte-mode request is therefore split wherever it meets a 256-unit boundary. The first command then covers the part that lies below buffer offset 256, and the second command starts at offset 256.

Between the two commands the block waits for a fixed number of clocks and also for an external flash-ready input. A request that cannot fit in the buffer is rejected before any bus activity. Each write strobe lasts a run-time number of clocks.

Top module: `nor_bufprog_seq`

## Requirements
- R1: After reset, `bus_ce_n` and `bus_we_n` are high, and `busy`, `done`, `err` and `src_ready` are low.
- R2: Each command issues these writes in order: data 0xAA to address 0x555; data 0x55 to address 0x2AA; data 0x25 to SA; the count to SA; one write per unit to consecutive addresses starting at SA; and finally data 0x29 to SA. SA is the start unit address of that command.
- R3: The count write carries the number of units in that command minus one, in the low 8 bits, so 0x00 means 1 unit and 0xFF means 256 units.
- R4: In x16 mode (`req_wide`=1), any accepted request of up to 256 words is issued as exactly one command.
- R5: In x8 mode (`req_wide`=0), a request is split at the 256-unit boundary into at most two commands. The second command starts at the unit whose address has the low 8 bits zero, which is buffer offset 256.
- R6: A request is rejected if its count is zero, or if its buffer offset plus its count is larger than the buffer size. The buffer size is 256 units in x16 mode and 512 units in x8 mode, and the buffer offset is the start address modulo that size. On rejection, `err` pulses for one clock, `busy` stays low and no bus cycle is issued.
- R7: For every write, `bus_we_n` is low for exactly `pulse_clks` clocks, with 0 treated as 1. `bus_ce_n` is low from one clock before the strobe until one clock after it, and the address and data do not change over that span.
- R8: Between the two commands of a split request, `bus_ce_n` stays high for at least GAP_CLKS clocks. It also stays high for as long as `flash_rdy` is low.
- R9: Data units are taken from the source in order, one per data write. `src_ready` is high only while a job is running, and a low `src_valid` stalls the data phase.
- R10: In x8 mode the upper byte of `bus_data` is zero on every write.
- R11: `done` pulses for one clock after the last write ends, and `busy` is low again at that point. A request presented while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Start unit address |
| req_units | input | $clog2(BUF_BYTES)+1 | Number of units to program |
| req_wide | input | 1 | 1 = x16 word units, 0 = x8 byte units |
| pulse_clks | input | PW_W | Write-strobe width in clocks (0 acts as 1) |
| flash_rdy | input | 1 | Flash ready; gates the second command |
| src_valid | input | 1 | Program data available |
| src_data | input | DATA_W | Program data unit |
| src_ready | output | 1 | Data unit taken this clock when `src_valid` is high |
| bus_addr | output | ADDR_W | Flash address |
| bus_data | output | DATA_W | Flash write data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-clock end-of-job pulse |
| err | output | 1 | One-clock request-rejected pulse |

## Verification
The hardest situation to reach is the handover between the two commands of a byte-mode job. At that point the confirm cycle has drained, and the block must wait on both its timer and `flash_rdy`. The bench reaches it with a full 512-byte request. It holds `flash_rdy` low until the first confirm write has been seen, keeps it low for a long window while watching chip-enable, and only then releases it. An unaligned byte-mode job starting at offset 250 drives the split into uneven halves. Source stalls and a stray request injected in the middle of a job check that the order of the data units and the command stream are not disturbed.

// File: rtl/nor_bp_pkg.sv
package nor_bp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_CMD, S_CNT, S_DATA, S_CONF, S_DRAIN, S_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SET, PH_STB, PH_HOLD
  } bus_phase_t;

  localparam logic [15:0] KEY_ADDR_1 = 16'h0555;
  localparam logic [15:0] KEY_ADDR_2 = 16'h02AA;
  localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
  localparam logic [7:0]  KEY_DATA_2 = 8'h55;
  localparam logic [7:0]  OP_LOAD    = 8'h25;
  localparam logic [7:0]  OP_COMMIT  = 8'h29;

endpackage

// File: rtl/nor_bp_plan.sv
// Validates a request and splits it at the count-field limit.
module nor_bp_plan #(
  parameter int ADDR_W    = 24,
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [$clog2(BUF_BYTES):0] units,
  input  logic                       wide,
  output logic                       bad,
  output logic [$clog2(BUF_BYTES):0] first,
  output logic [$clog2(BUF_BYTES):0] rest,
  output logic [ADDR_W-1:0]          rest_addr,
  output logic                       has_rest
);
  localparam int BAW = $clog2(BUF_BYTES);
  localparam int LW  = BAW + 1;

  logic [BAW-1:0] off;
  logic [LW:0]    sum, limit, room_x;
  logic [CNT_W:0] room;

  always_comb begin
    off = addr[BAW-1:0];
    if (wide) off[BAW-1] = 1'b0;
    sum    = (LW+1)'(off) + (LW+1)'(units);
    limit  = wide ? (LW+1)'(BUF_BYTES / 2) : (LW+1)'(BUF_BYTES);
    bad    = (units == '0) || (sum > limit);
    // units left before the next count-field boundary
    room   = ((CNT_W+1)'(1) << CNT_W) - (CNT_W+1)'(addr[CNT_W-1:0]);
    room_x = (LW+1)'(room);
    first  = ({1'b0, units} < room_x) ? units : room_x[LW-1:0];
    rest   = units - first;
    has_rest  = (rest != '0);
    rest_addr = addr + ADDR_W'(first);
  end

endmodule

// File: rtl/nor_bp_cycle.sv
// One bus write: setup clock, strobe of programmable width, hold clock.
module nor_bp_cycle
  import nor_bp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int PW_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  input  logic [PW_W-1:0]   width,
  output logic              ready,
  output logic              idle,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_ce_n,
  output logic              bus_we_n
);
  bus_phase_t      ph;
  logic [PW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      bus_addr <= '0;
      bus_data <= '0;
      bus_ce_n <= 1'b1;
      bus_we_n <= 1'b1;
    end else begin
      case (ph)
        PH_IDLE, PH_HOLD: begin
          if (go) begin
            ph       <= PH_SET;
            bus_ce_n <= 1'b0;
            bus_we_n <= 1'b1;
            bus_addr <= go_addr;
            bus_data <= go_data;
          end else begin
            ph       <= PH_IDLE;
            bus_ce_n <= 1'b1;
          end
        end
        PH_SET: begin
          ph       <= PH_STB;
          bus_we_n <= 1'b0;
          cnt      <= (width == '0) ? '0 : width - 1'b1;
        end
        PH_STB: begin
          if (cnt == '0) begin
            ph       <= PH_HOLD;
            bus_we_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign ready = (ph == PH_IDLE) || (ph == PH_HOLD);
  assign idle  = (ph == PH_IDLE);

  p_we_inside_ce_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> !bus_ce_n);
  p_bus_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> ($stable(bus_addr) && $stable(bus_data)));
  p_hold_clock_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we_n) |-> (!bus_ce_n && $stable(bus_addr) && $stable(bus_data)));

endmodule

// File: rtl/nor_bp_gap.sv
// Minimum idle time between the commands of a split job.
module nor_bp_gap #(
  parameter int GAP_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (GAP_CLKS < 1) ? 1 : $clog2(GAP_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= CW'(GAP_CLKS);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  p_gap_starts_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (expired == (GAP_CLKS == 0)));

endmodule

// File: rtl/nor_bufprog_seq.sv
module nor_bufprog_seq
  import nor_bp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int PW_W      = 4,
  parameter int GAP_CLKS  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [$clog2(BUF_BYTES):0] req_units,
  input  logic                       req_wide,
  input  logic [PW_W-1:0]            pulse_clks,
  input  logic                       flash_rdy,
  input  logic                       src_valid,
  input  logic [DATA_W-1:0]          src_data,
  output logic                       src_ready,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic [DATA_W-1:0]          bus_data,
  output logic                       bus_ce_n,
  output logic                       bus_we_n,
  output logic                       busy,
  output logic                       done,
  output logic                       err
);
  localparam int LW = $clog2(BUF_BYTES) + 1;
  localparam logic [LW:0] MAXU = (LW+1)'(1) << CNT_W;

  seq_state_t        state;
  logic [ADDR_W-1:0] sa_q, cur_q, addr2_q;
  logic [LW-1:0]     left_q, rest_q, left_m1;
  logic              has2_q, wide_q;

  logic              plan_bad, plan_has_rest;
  logic [LW-1:0]     plan_first, plan_rest;
  logic [ADDR_W-1:0] plan_rest_addr;

  logic              go, eng_ready, eng_idle, gap_load, gap_expired;
  logic [ADDR_W-1:0] go_addr;
  logic [DATA_W-1:0] go_data;

  nor_bp_plan #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_plan (
    .addr(req_addr), .units(req_units), .wide(req_wide),
    .bad(plan_bad), .first(plan_first), .rest(plan_rest),
    .rest_addr(plan_rest_addr), .has_rest(plan_has_rest)
  );

  nor_bp_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PW_W(PW_W)) u_cycle (
    .clk(clk), .rst(rst), .go(go), .go_addr(go_addr), .go_data(go_data),
    .width(pulse_clks), .ready(eng_ready), .idle(eng_idle),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n)
  );

  nor_bp_gap #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .expired(gap_expired)
  );

  assign left_m1   = left_q - 1'b1;
  assign src_ready = (state == S_DATA) && eng_ready;
  assign busy      = (state != S_IDLE);
  assign gap_load  = (state == S_DRAIN) && eng_idle && has2_q;

  // next bus write offered to the cycle engine
  always_comb begin
    go      = 1'b0;
    go_addr = sa_q;
    go_data = '0;
    case (state)
      S_UNL1: begin
        go = eng_ready; go_addr = ADDR_W'(KEY_ADDR_1); go_data = DATA_W'(KEY_DATA_1);
      end
      S_UNL2: begin
        go = eng_ready; go_addr = ADDR_W'(KEY_ADDR_2); go_data = DATA_W'(KEY_DATA_2);
      end
      S_CMD:  begin go = eng_ready; go_data = DATA_W'(OP_LOAD); end
      S_CNT:  begin go = eng_ready; go_data = DATA_W'(left_m1[CNT_W-1:0]); end
      S_DATA: begin
        go      = eng_ready && src_valid;
        go_addr = cur_q;
        go_data = wide_q ? src_data : DATA_W'(src_data[7:0]);
      end
      S_CONF: begin go = eng_ready; go_data = DATA_W'(OP_COMMIT); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sa_q    <= '0;
      cur_q   <= '0;
      addr2_q <= '0;
      left_q  <= '0;
      rest_q  <= '0;
      has2_q  <= 1'b0;
      wide_q  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (plan_bad) begin
            err <= 1'b1;
          end else begin
            sa_q    <= req_addr;
            cur_q   <= req_addr;
            left_q  <= plan_first;
            rest_q  <= plan_rest;
            addr2_q <= plan_rest_addr;
            has2_q  <= plan_has_rest;
            wide_q  <= req_wide;
            state   <= S_UNL1;
          end
        end
        S_UNL1: if (go) state <= S_UNL2;
        S_UNL2: if (go) state <= S_CMD;
        S_CMD:  if (go) state <= S_CNT;
        S_CNT:  if (go) state <= S_DATA;
        S_DATA: if (go) begin
          cur_q  <= cur_q + 1'b1;
          left_q <= left_m1;
          if (left_q == LW'(1)) state <= S_CONF;
        end
        S_CONF: if (go) state <= S_DRAIN;
        S_DRAIN: if (eng_idle) begin
          if (has2_q) begin
            sa_q   <= addr2_q;
            cur_q  <= addr2_q;
            left_q <= rest_q;
            has2_q <= 1'b0;
            state  <= S_GAP;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_GAP: if (gap_expired && flash_rdy) state <= S_UNL1;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && bus_ce_n));
  p_ready_in_job_r9: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);
  p_gap_bus_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> bus_ce_n);
  p_split_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !plan_bad && plan_has_rest) |-> (plan_rest_addr[CNT_W-1:0] == '0));
  p_chunk_fits_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !plan_bad) |-> (plan_first != '0 && {1'b0, plan_first} <= MAXU));
  p_done_alone_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !err));

endmodule

// File: tb/test_nor_bufprog_seq.sv
module test_nor_bufprog_seq;
  localparam int GAP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [9:0]  req_units = '0;
  logic        req_wide = 1'b0;
  logic [3:0]  pulse_clks = 4'd1;
  logic        flash_rdy = 1'b1;
  logic        src_valid = 1'b0;
  logic [15:0] src_data = '0;
  logic        src_ready, bus_ce_n, bus_we_n, busy, done, err;
  logic [23:0] bus_addr;
  logic [15:0] bus_data;

  nor_bufprog_seq #(.GAP_CLKS(GAP)) i_nor_bufprog_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_units(req_units), .req_wide(req_wide), .pulse_clks(pulse_clks),
    .flash_rdy(flash_rdy), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .busy(busy), .done(done), .err(err)
  );

  always #10 clk = ~clk;

  int checks = 0, bad = 0, cycles = 0;
  bit finished = 0;

  // reference model: expected write stream
  int          exp_a[$];
  logic [15:0] exp_d[$];
  int          exp_t[$];  // 0 data, 1 confirm, 2 first unlock, 3 count, 4 other command

  bit job_wide = 0;
  int src_seed = 0, src_idx = 0, tick = 0;
  bit src_stall = 0, rdy_prev = 0;
  int unlocks_seen = 0, confirms_seen = 0, err_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] pat(input int s, input int k);
    return 16'(s * 4099 + k * 613 + (k >> 2) * 7);
  endfunction

  function automatic string tag_req(input int t);
    case (t)
      0: return "R9 data";
      3: return "R3 count";
      default: return "R2 command";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  // data source
  always @(negedge clk) begin
    if (src_valid && rdy_prev) src_idx++;
    rdy_prev = src_ready;
    tick++;
    src_data  = pat(src_seed, src_idx);
    src_valid = src_stall ? (((src_idx + tick) % 3) != 0) : 1'b1;
  end

  // bus monitor, compared every clock
  bit          prev_we = 1, prev_ce = 1, after_confirm = 0;
  logic [23:0] prev_addr = '0, s_addr = '0;
  logic [15:0] s_data = '0;
  int          low_run = 0, high_run = 0, last_high_run = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (err) err_cnt++;
      if (bus_ce_n) high_run++;
      else if (prev_ce) begin last_high_run = high_run; high_run = 0; end
      if (!bus_we_n && bus_ce_n) chk(0, "R7", "we without ce", bus_ce_n, 0);
      if (prev_we && !bus_we_n) begin
        chk(!prev_ce && prev_addr == bus_addr, "R7", "setup clock", prev_addr, bus_addr);
        if (exp_a.size() == 0) begin
          chk(0, "R2", "unexpected write", bus_addr, 0);
        end else begin
          int a, t; logic [15:0] d;
          a = exp_a.pop_front(); d = exp_d.pop_front(); t = exp_t.pop_front();
          chk(bus_addr == 24'(a), tag_req(t), "address", bus_addr, a);
          chk(bus_data == d, tag_req(t), "data", bus_data, d);
          if (t == 2) begin
            unlocks_seen++;
            if (after_confirm) chk(last_high_run >= GAP, "R8", "gap clocks", last_high_run, GAP);
          end
          if (t == 1) begin confirms_seen++; after_confirm = 1; end
        end
        if (!job_wide) chk(bus_data[15:8] == 8'h00, "R10", "upper byte", bus_data[15:8], 0);
        low_run = 1; s_addr = bus_addr; s_data = bus_data;
      end else if (!prev_we && !bus_we_n) begin
        low_run++;
        if (bus_addr != s_addr || bus_data != s_data) chk(0, "R7", "strobe stability", bus_addr, s_addr);
      end else if (!prev_we && bus_we_n) begin
        chk(low_run == ((pulse_clks == 0) ? 1 : int'(pulse_clks)), "R7", "strobe width",
            low_run, (pulse_clks == 0) ? 1 : pulse_clks);
        chk(!bus_ce_n && bus_addr == s_addr && bus_data == s_data, "R7", "hold clock", bus_addr, s_addr);
      end
      prev_we = bus_we_n; prev_ce = bus_ce_n; prev_addr = bus_addr;
    end
  end

  task automatic run_job(input int a, input int u, input bit w, input int p, input int seed,
                         input bit stall, input bit poke, input bit hold_rdy);
    int ca, rem, k, chunks, hold_cnt;
    bit got_done, released, window_ok;
    ca = a; rem = u; k = 0; chunks = 0;
    while (rem > 0) begin
      int room, c;
      room = 256 - (ca % 256);
      c = (rem < room) ? rem : room;
      exp_a.push_back(32'h555); exp_d.push_back(16'h00AA); exp_t.push_back(2);
      exp_a.push_back(32'h2AA); exp_d.push_back(16'h0055); exp_t.push_back(4);
      exp_a.push_back(ca);      exp_d.push_back(16'h0025); exp_t.push_back(4);
      exp_a.push_back(ca);      exp_d.push_back(16'(c - 1)); exp_t.push_back(3);
      for (int i = 0; i < c; i++) begin
        exp_a.push_back(ca + i);
        exp_d.push_back(w ? pat(seed, k) : (pat(seed, k) & 16'h00FF));
        exp_t.push_back(0);
        k++;
      end
      exp_a.push_back(ca); exp_d.push_back(16'h0029); exp_t.push_back(1);
      ca += c; rem -= c; chunks++;
    end
    @(negedge clk);
    job_wide = w; pulse_clks = 4'(p); src_seed = seed; src_idx = 0; src_stall = stall;
    unlocks_seen = 0; confirms_seen = 0; err_cnt = 0; after_confirm = 0;
    flash_rdy = !hold_rdy;
    chk(!busy, "R11", "idle before job", busy, 0);
    req_addr = 24'(a); req_units = 10'(u); req_wide = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    got_done = 0; released = 0; hold_cnt = 0; window_ok = 1;
    for (int n = 0; n < 60000 && !got_done; n++) begin
      @(negedge clk);
      if (done) got_done = 1;
      if (poke && n == 40) begin req_addr = 24'h000123; req_units = 10'd0; req_wide = 1; req_valid = 1; end
      if (poke && n == 41) begin req_valid = 0; req_addr = 24'h000200; req_units = 10'd3; end
      if (poke && n == 42) req_valid = 1;
      if (poke && n == 43) req_valid = 0;
      if (hold_rdy && !released && confirms_seen == 1 && (hold_cnt > 0 || bus_ce_n)) begin
        if (!bus_ce_n) window_ok = 0;
        hold_cnt++;
        if (hold_cnt == 40) begin
          chk(window_ok, "R8", "bus idle while flash not ready", window_ok, 1);
          released = 1; flash_rdy = 1;
        end
      end
    end
    chk(got_done, "R11", "done seen", got_done, 1);
    chk(exp_a.size() == 0, "R2", "writes left", exp_a.size(), 0);
    chk(src_idx == u, "R9", "units consumed", src_idx, u);
    chk(unlocks_seen == chunks, w ? "R4" : "R5", "commands", unlocks_seen, chunks);
    chk(err_cnt == 0, "R11", "no err during job", err_cnt, 0);
    @(negedge clk);
    chk(!done && !busy, "R11", "done one clock", {done, busy}, 0);
    exp_a.delete(); exp_d.delete(); exp_t.delete();
    flash_rdy = 1;
  endtask

  task automatic err_job(input int a, input int u, input bit w, input string what);
    bit quiet;
    @(negedge clk);
    req_addr = 24'(a); req_units = 10'(u); req_wide = w; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(err == 1'b1, "R6", {what, " err"}, err, 1);
    chk(!busy, "R6", {what, " busy"}, busy, 0);
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!bus_ce_n || busy) quiet = 0;
      if (i == 0) chk(!err, "R6", {what, " err pulse"}, err, 0);
    end
    chk(quiet, "R6", {what, " no bus cycles"}, quiet, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(bus_ce_n && bus_we_n, "R1", "strobes idle", {bus_ce_n, bus_we_n}, 2'b11);
    chk(!busy && !done && !err && !src_ready, "R1", "flags", {busy, done, err, src_ready}, 0);

    run_job(32'h001000, 256, 1, 2, 1, 0, 0, 0);   // R4 full word buffer, count 0xFF
    run_job(32'h002000, 512, 0, 1, 2, 0, 0, 1);   // R5 R8 full byte buffer, ready held low
    run_job(32'h0030FA, 10,  0, 3, 3, 1, 0, 0);   // R5 uneven split 6+4, stalls
    run_job(32'h004005, 1,   1, 0, 4, 0, 0, 0);   // R3 single unit, width 0 acts as 1
    run_job(32'h005080, 100, 1, 2, 5, 1, 1, 0);   // R11 stray requests ignored while busy
    run_job(32'h006100, 256, 0, 1, 6, 0, 0, 0);   // R5 starts at offset 256, one command

    err_job(32'h007000, 0,   1, "zero length");
    err_job(32'h007000, 257, 1, "over word buffer");
    err_job(32'h007000, 513, 0, "over byte buffer");
    err_job(32'h0070C8, 100, 1, "word boundary crossing");
    err_job(32'h00712C, 300, 0, "byte boundary crossing");

    summary();
  end

endmodule